// File: doc/BRIEF.md
# Bitstream-to-PCM Decimation Chain

This block turns a one-bit oversampled stream into 20-bit PCM samples for one channel, with a total rate reduction of 128. Each enabled input bit counts as +1 or −1. A third-order comb-integrator stage reduces the rate by 16. Three cascaded half-band FIR stages follow, and each of them halves the rate again. A final stage rounds the result to 20 bits, saturates it, and marks every new sample with a one-clock strobe.

The block runs on a fast system clock. `en_i` marks each clock in which a new input bit is present, so the bit rate can be any integer fraction of the clock. Later stages are triggered by the strobe of the stage before them, not by `en_i`. Because of this, the delay from an enabled input to the output is the same number of clocks whatever the enable cadence. After a reset the filter memories are zero, and the first few samples are settling transients.

Top module: `decim_chain`

## Requirements
- R1: An input bit of 1 counts as +1 and a bit of 0 counts as −1. A constant-0 input settles to exactly −524288 (0x80000).
- R2: `valid_o` is high for exactly one clock at a time and pulses once per 128 enabled inputs. When `en_i` is high one clock in every g+1, consecutive strobes are 128·(g+1) clocks apart.
- R3: While `en_i` stays low, no strobe appears once the pipeline has drained (at most 8 clocks).
- R4: End-to-end DC gain is exactly one. A repeating 8-bit pattern with ones-density d settles to exactly 524288·(2d−1) when that value is in range: d=6/8 gives 262144, d=2/8 gives −262144, d=5/8 gives 131072, d=3/8 gives −131072, d=7/8 gives 393216.
- R5: A constant-1 input, whose ideal value is +524288, settles to the saturated maximum 524287 (0x7FFFF) and never wraps to a negative value.
- R6: While `rst_ni` is low, `valid_o` is 0 and `sample_o` is 0, with no clock edge needed.
- R7: `sample_o` changes only in a clock where `valid_o` is high.
- R8: After reset, the first strobe follows the 128th enabled input. 127 enabled inputs produce no strobe.
- R9: An alternating 1/0 input, which is the highest input frequency, settles to exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | High in each clock that carries a new input bit |
| bit_i | input | 1 | Oversampled one-bit input, sampled when en_i is high |
| sample_o | output | 20 | Two's-complement output sample |
| valid_o | output | 1 | One-clock strobe marking a new sample_o |

## Verification
Two things can happen in the same clock. The comb-integrator can accept the first bit of a new 16-bit window while the half-band stages are still passing the previous window's result towards the output register. Inputs arrive every clock, or every second or third clock. With back-to-back enables, new integration overlaps every downstream compute and every strobe. The judgement is exact settled values, on a per-pattern table and with no tolerance, together with exact strobe spacing. A reset pulled in the middle of a run also has to clear the outputs before the next clock edge.

// File: rtl/decim_pkg.sv
package decim_pkg;
  localparam int OUT_W     = 20;
  localparam int CIC_R     = 16;
  localparam int CIC_N     = 3;
  localparam int HB_STAGES = 3;
  localparam int FRAC_W    = 4;
  localparam int HB_TAPS   = 7;
  localparam int HB_SHIFT  = 5;
  // half-band kernel, sum 32: odd taps around centre are zero
  localparam int HB_COEF [HB_TAPS] = '{-1, 0, 9, 16, 9, 0, -1};
endpackage

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int R = 16,
  parameter int N = 3,
  parameter int W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                bit_i,
  output logic signed [W-1:0] dat_o,
  output logic                vld_o
);
  localparam int CW = $clog2(R);

  logic [CW-1:0]       phase_q;
  logic signed [W-1:0] x;
  logic signed [W-1:0] integ_q [N];
  logic signed [W-1:0] dly_q   [N];
  logic signed [W-1:0] diff    [N+1];

  assign x = bit_i ? {{(W-1){1'b0}}, 1'b1} : {W{1'b1}};

  // integrators, wrap-around arithmetic
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) integ_q[k] <= '0;
    end else if (en_i) begin
      integ_q[0] <= integ_q[0] + x;
      for (int k = 1; k < N; k++) integ_q[k] <= integ_q[k] + integ_q[k-1];
    end
  end

  assign diff[0] = integ_q[N-1];
  for (genvar g = 0; g < N; g++) begin : g_comb
    assign diff[g+1] = diff[g] - dly_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      dat_o   <= '0;
      vld_o   <= 1'b0;
      for (int k = 0; k < N; k++) dly_q[k] <= '0;
    end else begin
      vld_o <= 1'b0;
      if (en_i) begin
        phase_q <= phase_q + 1'b1;
        if (phase_q == CW'(R-1)) begin
          for (int k = 0; k < N; k++) dly_q[k] <= diff[k];
          dat_o <= diff[N];
          vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hb_decim.sv
module hb_decim
  import decim_pkg::*;
#(
  parameter int W = 26
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] dat_i,
  input  logic                vld_i,
  output logic signed [W-1:0] dat_o,
  output logic                vld_o
);
  localparam int AW = W + 6;
  localparam logic signed [AW-1:0] HALF = AW'(1 <<< (HB_SHIFT-1));

  logic signed [W-1:0]  tap_q [HB_TAPS-1];
  logic signed [W-1:0]  win   [HB_TAPS];
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] rnd;
  logic                 odd_q;

  assign win[0] = dat_i;
  for (genvar g = 1; g < HB_TAPS; g++) begin : g_win
    assign win[g] = tap_q[g-1];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < HB_TAPS; k++) acc = acc + AW'(win[k]) * AW'(HB_COEF[k]);
    rnd = (acc + HALF) >>> HB_SHIFT;
  end

  // computes only on every second input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < HB_TAPS-1; k++) tap_q[k] <= '0;
      odd_q <= 1'b0;
      dat_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (vld_i) begin
        tap_q[0] <= dat_i;
        for (int k = 1; k < HB_TAPS-1; k++) tap_q[k] <= tap_q[k-1];
        odd_q <= ~odd_q;
        if (odd_q) begin
          dat_o <= rnd[W-1:0];
          vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/out_quant.sv
module out_quant #(
  parameter int IN_W   = 26,
  parameter int OUT_W  = 20,
  parameter int FRAC_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  dat_i,
  input  logic                    vld_i,
  output logic signed [OUT_W-1:0] dat_o,
  output logic                    vld_o
);
  localparam int SW = IN_W + 1;
  localparam logic signed [SW-1:0] MAX_V = SW'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [SW-1:0] MIN_V = SW'(-(64'sd1 <<< (OUT_W-1)));
  localparam logic signed [SW-1:0] HALF  = SW'(1 <<< (FRAC_W-1));

  logic signed [SW-1:0]    sh;
  logic signed [OUT_W-1:0] q;

  assign sh = (SW'(dat_i) + HALF) >>> FRAC_W;

  always_comb begin
    if (sh > MAX_V)      q = MAX_V[OUT_W-1:0];
    else if (sh < MIN_V) q = MIN_V[OUT_W-1:0];
    else                 q = sh[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) dat_o <= q;
    end
  end
endmodule

// File: rtl/decim_chain.sv
module decim_chain
  import decim_pkg::*;
#(
  parameter int P_OUT_W     = OUT_W,
  parameter int P_CIC_R     = CIC_R,
  parameter int P_CIC_N     = CIC_N,
  parameter int P_HB_STAGES = HB_STAGES,
  parameter int P_FRAC_W    = FRAC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               bit_i,
  output logic [P_OUT_W-1:0] sample_o,
  output logic               valid_o
);
  localparam int CIC_GROW = P_CIC_N * $clog2(P_CIC_R);
  localparam int CIC_W    = CIC_GROW + 2;
  localparam int DP_W     = P_OUT_W + P_FRAC_W + 2;
  localparam int SCALE    = P_OUT_W - 1 + P_FRAC_W - CIC_GROW;

  logic signed [CIC_W-1:0]   cic_dat;
  logic                      cic_vld;
  logic signed [DP_W-1:0]    st_dat [P_HB_STAGES+1];
  logic                      st_vld [P_HB_STAGES+1];
  logic signed [P_OUT_W-1:0] q_dat;

  cic_decim #(.R(P_CIC_R), .N(P_CIC_N), .W(CIC_W)) i_cic (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .bit_i (bit_i),
    .dat_o (cic_dat),
    .vld_o (cic_vld)
  );

  // full-scale comb output maps to 2^(OUT_W-1) in output LSBs
  assign st_dat[0] = DP_W'(cic_dat) <<< SCALE;
  assign st_vld[0] = cic_vld;

  for (genvar s = 0; s < P_HB_STAGES; s++) begin : g_hb
    hb_decim #(.W(DP_W)) i_hb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .dat_i (st_dat[s]),
      .vld_i (st_vld[s]),
      .dat_o (st_dat[s+1]),
      .vld_o (st_vld[s+1])
    );
  end

  out_quant #(.IN_W(DP_W), .OUT_W(P_OUT_W), .FRAC_W(P_FRAC_W)) i_quant (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dat_i (st_dat[P_HB_STAGES]),
    .vld_i (st_vld[P_HB_STAGES]),
    .dat_o (q_dat),
    .vld_o (valid_o)
  );

  assign sample_o = q_dat;
endmodule

// File: rtl/decim_chain_chk.sv
module decim_chain_chk #(
  parameter int DECIM = 128,
  parameter int OUT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [OUT_W-1:0] sample_o,
  input logic             valid_o
);
  localparam int CNT_W = $clog2(DECIM) + 2;

  logic [CNT_W-1:0] gap_q;
  logic [3:0]       idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             gap_q <= '0;
    else if (valid_o)        gap_q <= '0;
    else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             idle_q <= '0;
    else if (en_i)           idle_q <= '0;
    else if (idle_q != '1)   idle_q <= idle_q + 1'b1;
  end

  AST_STROBE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> gap_q >= CNT_W'(DECIM-1)); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q >= 4'd8 |-> !valid_o); // R3

  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o)); // R7

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!valid_o && sample_o == '0); // R6
    end
  end
endmodule

bind decim_chain decim_chain_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .sample_o(sample_o),
  .valid_o (valid_o)
);

// File: tb/test_decim_chain.sv
`timescale 1ns/1ps
module test_decim_chain;
  localparam int NV = 8;
  localparam logic [7:0] V_PAT [NV] = '{8'hFF, 8'h00, 8'hAA, 8'hEE, 8'h11, 8'h1F, 8'h07, 8'h7F};
  localparam int         V_GAP [NV] = '{0, 0, 1, 0, 1, 0, 2, 0};
  localparam int         V_EXP [NV] = '{524287, -524288, 0, 262144, -262144, 131072, -131072, 393216};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        bit_i = 1'b0;
  logic [19:0] sample_o;
  logic        valid_o;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int vcnt = 0;
  int wide_cnt = 0;
  int hold_err = 0;
  int hist_v [512];
  int hist_t [512];
  logic prev_v = 1'b0;
  logic prev_rst = 1'b0;
  logic [19:0] prev_s = '0;
  bit done = 1'b0;

  decim_chain i_decim_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .bit_i   (bit_i),
    .sample_o(sample_o),
    .valid_o (valid_o)
  );

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  always @(negedge clk_i) begin
    if (valid_o) begin
      if (vcnt < 512) begin
        hist_v[vcnt] = int'($signed(sample_o));
        hist_t[vcnt] = cyc;
      end
      vcnt++;
      if (prev_v) wide_cnt++;
    end
    if (rst_ni && prev_rst && !valid_o && sample_o != prev_s) hold_err++;
    prev_v   = valid_o;
    prev_rst = rst_ni;
    prev_s   = sample_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i   = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic feed(input logic [7:0] pat, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      en_i  = 1'b1;
      bit_i = pat[i % 8];
      repeat (gap) begin
        @(negedge clk_i);
        en_i = 1'b0;
      end
    end
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic string tag_of(input logic [7:0] p);
    if (p == 8'hFF) return "R5";
    if (p == 8'h00) return "R1";
    if (p == 8'hAA) return "R9";
    return "R4";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
    finish_run();
  end

  initial begin
    int base;
    int s_hold;
    // R6: reset state
    idle(2);
    chk(valid_o == 1'b0 && sample_o == '0, "R6", int'(sample_o), 0);
    rst_ni = 1'b1;

    foreach (V_PAT[r]) begin
      do_reset();
      base = vcnt;
      feed(V_PAT[r], 16 * 128, V_GAP[r]);
      idle(20);
      chk(vcnt - base == 16, "R2", vcnt - base, 16);
      for (int j = 12; j < 16; j++)
        chk(hist_v[base+j] == V_EXP[r], tag_of(V_PAT[r]), hist_v[base+j], V_EXP[r]);
      chk(hist_t[base+15] - hist_t[base+14] == 128 * (V_GAP[r] + 1), "R2",
          hist_t[base+15] - hist_t[base+14], 128 * (V_GAP[r] + 1));
    end

    // R3 and R7: long idle after a run, no strobe, sample held
    s_hold = int'($signed(sample_o));
    base = vcnt;
    idle(300);
    chk(vcnt == base, "R3", vcnt - base, 0);
    chk(int'($signed(sample_o)) == s_hold, "R7", int'($signed(sample_o)), s_hold);

    // R8: first strobe needs the 128th enabled input
    do_reset();
    base = vcnt;
    feed(8'hFF, 127, 0);
    idle(20);
    chk(vcnt == base, "R8", vcnt - base, 0);
    feed(8'hFF, 1, 0);
    idle(10);
    chk(vcnt == base + 1, "R8", vcnt - base, 1);

    // R6: asynchronous clear in the middle of a run
    do_reset();
    feed(8'hFF, 1500, 0);
    chk(sample_o != '0, "R6", int'(sample_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    chk(valid_o == 1'b0 && sample_o == '0, "R6", int'(sample_o), 0);
    idle(2);
    rst_ni = 1'b1;
    idle(2);

    chk(wide_cnt == 0, "R2", wide_cnt, 0);
    chk(hold_err == 0, "R7", hold_err, 0);
    finish_run();
  end
endmodule